// File: doc/BRIEF.md
# Parallel-load serial-out shift register

This block is an eight-stage shift register that can take a whole byte at once or accept serial data one bit at a time. It presents the content of its final stage as a serial output, together with the inverse of that bit. The block suits designs that turn a byte of parallel data into a bit stream for an external link or for daisy-chained registers.

Two external clock-type pins control shifting. A shift takes place when the logical OR of the two pins rises. Either pin can therefore serve as the shift clock, and holding the other pin high blocks it. Both pins are asynchronous to the system clock, so each one passes through its own synchroniser before the rise is detected. A level-sensitive load control, active low, copies the parallel inputs into every stage on each system cycle in which it is low. Load takes priority over any shift.

Top module: `piso_shreg`

## Requirements
- R1: While `rst` is high at a rising `clk` edge, every stage is cleared. After that edge `ser_out` is 0 and `ser_out_n` is 1.
- R2: On each rising `clk` edge at which `shift_nload` is 0, stage i takes `par_in[i]`. This happens whatever the clock pins are doing. Stage 0 is the first stage and stage WIDTH-1 is the last. `ser_out` shows the last stage, so right after a load it equals `par_in[WIDTH-1]`.
- R3: Suppose `shift_nload` is 1, `clk_pin_b` is low, and `clk_pin_a` rises. The register then shifts once: stage 0 takes `ser_in` and stage i takes stage i-1. The change appears on the third rising `clk` edge, counting the first edge at which the pin is high as the first.
- R4: `clk_pin_b` rising while `clk_pin_a` is low produces the same single shift, with the same latency.
- R5: While either pin is held high, rising edges on the other pin cause no shift.
- R6: When `shift_nload` is 1 and no qualifying rise occurs, the contents stay unchanged.
- R7: After reset, `ser_out_n` is always the inverse of `ser_out`.
- R8: If a detected shift event falls on a cycle in which `shift_nload` is 0, the load takes effect and the shift is discarded.
- R9: A shift event detected on the first cycle after `shift_nload` returns to 1 acts on the freshly loaded contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| shift_nload | input | 1 | 1 = shift/hold, 0 = parallel load |
| clk_pin_a | input | 1 | Asynchronous clock-type pin A |
| clk_pin_b | input | 1 | Asynchronous clock-type pin B |
| ser_in | input | 1 | Serial data entering stage 0 |
| par_in | input | WIDTH | Parallel data, bit i to stage i |
| ser_out | output | 1 | Last stage value |
| ser_out_n | output | 1 | Inverse of last stage value |

## Verification
The bench uses the default WIDTH of 8 and SYNC_STAGES of 2. With these values a full byte readout takes eight pin pulses, and the three-cycle delay from pin to shift is short enough to place a shift event exactly on the cycle a load ends, or inside a load window. The behavioural model tracks the OR of the two pins as a sample history. It then predicts the last stage on every cycle, which covers both pin roles and the blocking of either pin.

// File: rtl/psr_pkg.sv
package psr_pkg;
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_SHIFT = 2'd1,
    OP_LOAD  = 2'd2
  } stage_op_e;
endpackage

// File: rtl/psr_sync.sv
module psr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/psr_edge.sv
module psr_edge #(
  parameter int NPINS = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] lv,
  output logic             evt
);
  logic any_hi;
  logic prev;

  assign any_hi = |lv;

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b0;
    else     prev <= any_hi;
  end

  assign evt = any_hi & ~prev;

  // R5
  no_double_evt_chk: assert property (@(posedge clk) disable iff (rst)
    evt |=> !evt);
endmodule

// File: rtl/psr_core.sv
module psr_core
  import psr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shift_nload,
  input  logic             shift_evt,
  input  logic             ser_in,
  input  logic [WIDTH-1:0] par_in,
  output logic             ser_out,
  output logic             ser_out_n
);
  logic [WIDTH-1:0] stages;
  logic [WIDTH-1:0] nxt;
  stage_op_e        op;

  always_comb begin
    if (!shift_nload)   op = OP_LOAD;
    else if (shift_evt) op = OP_SHIFT;
    else                op = OP_HOLD;
  end

  always_comb begin
    case (op)
      OP_LOAD:  nxt = par_in;
      OP_SHIFT: nxt = {stages[WIDTH-2:0], ser_in};
      default:  nxt = stages;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stages    <= '0;
      ser_out   <= 1'b0;
      ser_out_n <= 1'b1;
    end else begin
      stages    <= nxt;
      ser_out   <= nxt[WIDTH-1];
      ser_out_n <= ~nxt[WIDTH-1];
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (stages == '0 && ser_out_n));
  // R2
  load_capture_chk: assert property (@(posedge clk) disable iff (rst)
    !shift_nload |=> stages == $past(par_in));
  // R3
  shift_step_chk: assert property (@(posedge clk) disable iff (rst)
    (shift_nload && shift_evt) |=>
      stages == {$past(stages[WIDTH-2:0]), $past(ser_in)});
  // R6
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (shift_nload && !shift_evt) |=> $stable(stages));
  // R7
  compl_out_chk: assert property (@(posedge clk) disable iff (rst)
    ser_out_n == ~ser_out);
endmodule

// File: rtl/piso_shreg.sv
module piso_shreg #(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shift_nload,
  input  logic             clk_pin_a,
  input  logic             clk_pin_b,
  input  logic             ser_in,
  input  logic [WIDTH-1:0] par_in,
  output logic             ser_out,
  output logic             ser_out_n
);
  localparam int NPINS = 2;

  logic [NPINS-1:0] pins_raw;
  logic [NPINS-1:0] pins_sy;
  logic             shift_evt;

  assign pins_raw = {clk_pin_b, clk_pin_a};

  for (genvar g = 0; g < NPINS; g++) begin : g_sync
    psr_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .rst (rst),
      .d   (pins_raw[g]),
      .q   (pins_sy[g])
    );
  end

  psr_edge #(.NPINS(NPINS)) u_edge (
    .clk (clk),
    .rst (rst),
    .lv  (pins_sy),
    .evt (shift_evt)
  );

  psr_core #(.WIDTH(WIDTH)) u_core (
    .clk         (clk),
    .rst         (rst),
    .shift_nload (shift_nload),
    .shift_evt   (shift_evt),
    .ser_in      (ser_in),
    .par_in      (par_in),
    .ser_out     (ser_out),
    .ser_out_n   (ser_out_n)
  );
endmodule

// File: tb/piso_shreg_tb.sv
module piso_shreg_tb;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         shift_nload = 1'b1;
  logic         clk_pin_a = 1'b0;
  logic         clk_pin_b = 1'b0;
  logic         ser_in = 1'b0;
  logic [W-1:0] par_in = '0;
  logic         ser_out, ser_out_n;

  int    n_chk = 0;
  int    n_fail = 0;
  bit    done = 0;
  string tag = "R1";

  logic [W-1:0] m;
  int           hist[$];

  always #5 clk = ~clk;

  piso_shreg #(.WIDTH(W), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst(rst), .shift_nload(shift_nload),
    .clk_pin_a(clk_pin_a), .clk_pin_b(clk_pin_b),
    .ser_in(ser_in), .par_in(par_in),
    .ser_out(ser_out), .ser_out_n(ser_out_n)
  );

  // Model: a shift fires when the pin OR was 1 two edges ago and 0 three edges ago.
  initial hist = '{0, 0, 0};
  always @(posedge clk) begin
    if (rst) begin
      m = '0;
      hist.push_front(0);
      void'(hist.pop_back());
    end else begin
      if (!shift_nload) m = par_in;
      else if (hist[1] == 1 && hist[2] == 0) m = {m[W-2:0], ser_in};
      hist.push_front((clk_pin_a | clk_pin_b) ? 1 : 0);
      void'(hist.pop_back());
    end
  end

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      check(tag, ser_out, m[W-1]);
      check("R7", ser_out_n, ~m[W-1]);
    end
  end

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_a();
    clk_pin_a = 1'b1; cycles(4);
    clk_pin_a = 1'b0; cycles(4);
  endtask

  task automatic pulse_b();
    clk_pin_b = 1'b1; cycles(4);
    clk_pin_b = 1'b0; cycles(4);
  endtask

  task automatic do_load(input logic [W-1:0] v);
    par_in = v; shift_nload = 1'b0; cycles(2);
    shift_nload = 1'b1; cycles(1);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] got;
    logic         keep;
    cycles(3);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1", ser_out, 1'b0);
    check("R1", ser_out_n, 1'b1);

    // R2 load, R3 readout via pin A
    tag = "R2";
    do_load(8'hA5);
    check("R2", ser_out, 1'b1);
    tag = "R3";
    ser_in = 1'b0;
    got = '0;
    for (int i = 0; i < W; i++) begin
      got[W-1-i] = ser_out;
      pulse_a();
    end
    n_chk++;
    if (got !== 8'hA5) begin
      n_fail++;
      $display("FAIL R3: got %h expected %h", got, 8'hA5);
    end
    check("R3", ser_out, 1'b0);

    // R4 readout via pin B, serial ones entering
    tag = "R4";
    do_load(8'h3C);
    ser_in = 1'b1;
    got = '0;
    for (int i = 0; i < W; i++) begin
      got[W-1-i] = ser_out;
      pulse_b();
    end
    n_chk++;
    if (got !== 8'h3C) begin
      n_fail++;
      $display("FAIL R4: got %h expected %h", got, 8'h3C);
    end
    check("R4", ser_out, 1'b1);

    // R5 pin B held high blocks pin A, and the reverse
    tag = "R5";
    ser_in = 1'b0;
    do_load(8'hC0);
    clk_pin_b = 1'b1; cycles(5);
    keep = ser_out;
    for (int i = 0; i < 3; i++) pulse_a();
    check("R5", ser_out, keep);
    clk_pin_b = 1'b0; cycles(4);
    clk_pin_a = 1'b1; cycles(5);
    keep = ser_out;
    for (int i = 0; i < 3; i++) pulse_b();
    check("R5", ser_out, keep);
    clk_pin_a = 1'b0; cycles(4);

    // R6 hold with no edges
    tag = "R6";
    do_load(8'h80);
    keep = ser_out;
    cycles(20);
    check("R6", ser_out, keep);

    // R8 shift event inside a load window
    tag = "R8";
    par_in = 8'h80;
    shift_nload = 1'b0;
    clk_pin_a = 1'b1;
    cycles(5);
    shift_nload = 1'b1;
    cycles(2);
    check("R8", ser_out, 1'b1);
    clk_pin_a = 1'b0; cycles(4);

    // R9 shift event on the first cycle after load release
    tag = "R9";
    par_in = 8'h80;
    ser_in = 1'b1;
    shift_nload = 1'b0;
    @(negedge clk);
    clk_pin_a = 1'b1;
    @(negedge clk);
    @(negedge clk);
    shift_nload = 1'b1;
    @(negedge clk);
    check("R9", ser_out, 1'b0);
    clk_pin_a = 1'b0;
    cycles(4);

    // R1 reset mid-run
    tag = "R1";
    rst = 1'b1; cycles(2);
    check("R1", ser_out, 1'b0);
    check("R1", ser_out_n, 1'b1);
    rst = 1'b0; cycles(3);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule